// File: doc/BRIEF.md
# Prefixed Opcode Decode Stage

This block is the first decode stage of an 8-bit processor. Fetched instruction bytes arrive one at a time, each qualified by a valid strobe. The stage looks for an optional modifier byte (a prefix) in front of the main opcode and turns it into two addressing-mode modifiers: a flag that selects the Y index register in place of X, and a flag that selects the indirect form of the addressing mode. An instruction is one to four bytes long: the optional prefix, the opcode, and then zero to two operand bytes that later stages use to form the effective address.

When the opcode byte is accepted, the stage presents the opcode, both modifier flags and the number of operand bytes for one cycle. It then lets that many further bytes pass without decoding them, and goes back to waiting for the first byte of the next instruction. Two parameter tables give, for every byte value, whether it is a defined opcode and how many operand bytes follow it. A byte that is neither a prefix nor a defined opcode raises a one-cycle request to reset the processor. A prefix followed by a defined opcode never raises that request, even when the pair is not an authorised combination.

Top module: `pbd_decode`

## Requirements
- R1: After reset, and until a byte is accepted, `dec_vld` and `illegal_rst` are low and the stage waits for the first byte of an instruction.
- R2: Prefix 0x90 in front of an opcode gives `dec_use_y`=1 and `dec_indirect`=0 on that opcode's decode.
- R3: Prefix 0x92 in front of an opcode gives `dec_use_y`=0 and `dec_indirect`=1 on that opcode's decode.
- R4: Prefix 0x91 in front of an opcode gives `dec_use_y`=1 and `dec_indirect`=1 on that opcode's decode.
- R5: An opcode with no prefix decodes with `dec_use_y`=0 and `dec_indirect`=0.
- R6: The byte right after a prefix is always taken as the opcode; a prefix value in that slot goes through the opcode table (with the default table 0x90, 0x91 and 0x92 are defined opcodes with no operands) and keeps the modifiers of the first prefix.
- R7: An accepted first-slot byte that is not a prefix and is undefined in the opcode table gives `illegal_rst`=1 for exactly one cycle, the cycle after the byte, with `dec_vld` low. With the default table the undefined bytes are 0x8C, 0x8D, 0x8E, 0x8F, 0x31 and 0x93.
- R8: A prefix followed by any defined opcode gives no `illegal_rst`, whatever the pair; a prefix followed by an undefined opcode gives the one-cycle `illegal_rst` and no decode.
- R9: `dec_vld` is high for one cycle, the cycle after the opcode byte is accepted, with `dec_opcode` equal to that byte and `dec_opnd_cnt` taken from the length table. Default lengths: for bytes below 0x80, bits 5:4 equal to 0 give 0, 1 gives 1, 2 or 3 give 2; for bytes 0x80 and above, bit 6 set gives 1, clear gives 0.
- R10: After an opcode with count n, the next n accepted bytes are operands: they give neither `dec_vld` nor `illegal_rst` whatever their value, and the byte after them is a first-slot byte again.
- R11: A cycle with `byte_vld` low is ignored: it produces no decode and no reset request and does not move the stage on, whatever `byte_in` holds.
- R12: A byte accepted in the same cycle that `illegal_rst` is high is treated as the first byte of a new instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | `byte_in` holds a fetched byte this cycle |
| byte_in | input | 8 | Fetched instruction byte |
| dec_vld | output | 1 | One-cycle strobe: decoded fields are valid |
| dec_opcode | output | 8 | Main opcode byte |
| dec_use_y | output | 1 | Use the Y index register instead of X |
| dec_indirect | output | 1 | Use the indirect form of the addressing mode |
| dec_opnd_cnt | output | 2 | Operand bytes following the opcode (0 to 2) |
| illegal_rst | output | 1 | One-cycle request to reset on an undefined byte |

## Verification
The reset request for an undefined byte and the acceptance of the first byte of the next instruction can fall in the same cycle, because the stage returns to its first-slot state while the request is still high. The bench provokes this by sending an undefined byte and, with no gap, a defined opcode that carries operands. It judges the overlap by requiring a single-cycle request followed in the next cycle by a correct decode of the new opcode with its own operand count. It also sends an undefined byte directly after a prefix, so that the pending modifiers and the fault detection meet on one byte, and requires the reset request with no decode.

// File: rtl/pbd_pkg.sv
package pbd_pkg;

  localparam int OP_W  = 8;
  localparam int OP_N  = 1 << OP_W;
  localparam int CNT_W = 2;

  typedef enum logic [1:0] {
    PK_NONE  = 2'd0,
    PK_Y     = 2'd1,
    PK_IND   = 2'd2,
    PK_IND_Y = 2'd3
  } pre_kind_t;

  typedef struct packed {
    logic use_y;
    logic indirect;
  } amod_t;

  function automatic amod_t kind_to_mod(pre_kind_t k);
    amod_t m;
    m.use_y    = (k == PK_Y) || (k == PK_IND_Y);
    m.indirect = (k == PK_IND) || (k == PK_IND_Y);
    return m;
  endfunction

  // Default set of defined opcodes: everything except a small hole set.
  function automatic logic [OP_N-1:0] dflt_legal();
    logic [OP_N-1:0] t;
    for (int i = 0; i < OP_N; i++) begin
      logic [OP_W-1:0] b;
      b = OP_W'(i);
      t[i] = !(((b[7:4] == 4'h8) && (b[3:2] == 2'b11)) ||
               (b == 8'h31) || (b == 8'h93));
    end
    return t;
  endfunction

  // Default operand-length table, CNT_W bits per opcode.
  function automatic logic [CNT_W*OP_N-1:0] dflt_len();
    logic [CNT_W*OP_N-1:0] t;
    for (int i = 0; i < OP_N; i++) begin
      logic [OP_W-1:0] b;
      logic [CNT_W-1:0] n;
      b = OP_W'(i);
      if (!b[7]) begin
        n = (b[5:4] == 2'd0) ? 2'd0 : ((b[5:4] == 2'd1) ? 2'd1 : 2'd2);
      end else begin
        n = b[6] ? 2'd1 : 2'd0;
      end
      t[CNT_W*i +: CNT_W] = n;
    end
    return t;
  endfunction

endpackage

// File: rtl/pbd_lookup.sv
module pbd_lookup
  import pbd_pkg::*;
#(
  parameter int                     W         = OP_W,
  parameter int                     CW        = CNT_W,
  parameter logic [W-1:0]           PRE_Y     = 8'h90,
  parameter logic [W-1:0]           PRE_IND   = 8'h92,
  parameter logic [W-1:0]           PRE_IND_Y = 8'h91,
  parameter logic [(1<<W)-1:0]      LEGAL_MAP = dflt_legal(),
  parameter logic [CW*(1<<W)-1:0]   LEN_MAP   = dflt_len()
) (
  input  logic [W-1:0]  byte_in,
  output pre_kind_t     pre_kind,
  output logic          is_legal,
  output logic [CW-1:0] opnd_cnt
);

  localparam int NPRE = 3;
  localparam logic [NPRE*W-1:0] PRE_CODES = {PRE_IND_Y, PRE_IND, PRE_Y};
  localparam logic [NPRE*2-1:0] PRE_KINDS = {PK_IND_Y, PK_IND, PK_Y};

  logic [NPRE-1:0] hit;

  for (genvar g = 0; g < NPRE; g++) begin : g_pre
    assign hit[g] = (byte_in == PRE_CODES[g*W +: W]);
  end

  always_comb begin
    pre_kind = PK_NONE;
    for (int k = 0; k < NPRE; k++) begin
      if (hit[k]) pre_kind = pre_kind_t'(PRE_KINDS[k*2 +: 2]);
    end
  end

  assign is_legal = LEGAL_MAP[byte_in];
  assign opnd_cnt = LEN_MAP[int'(byte_in)*CW +: CW];

endmodule

// File: rtl/pbd_seq.sv
module pbd_seq
  import pbd_pkg::*;
#(
  parameter int W  = OP_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          byte_vld,
  input  logic [W-1:0]  byte_in,
  input  pre_kind_t     pre_kind,
  input  logic          is_legal,
  input  logic [CW-1:0] opnd_cnt,
  output logic          dec_vld,
  output logic [W-1:0]  dec_opcode,
  output logic          dec_use_y,
  output logic          dec_indirect,
  output logic [CW-1:0] dec_opnd_cnt,
  output logic          illegal_rst
);

  typedef enum logic [1:0] {
    ST_FIRST = 2'd0,
    ST_OPC   = 2'd1,
    ST_OPND  = 2'd2
  } st_t;

  st_t           st_q;
  pre_kind_t     pend_q;
  logic [CW-1:0] left_q;
  amod_t         mod_now;

  // In the opcode slot the pending prefix applies; in the first slot none.
  assign mod_now = kind_to_mod((st_q == ST_OPC) ? pend_q : PK_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_FIRST;
      pend_q       <= PK_NONE;
      left_q       <= '0;
      dec_vld      <= 1'b0;
      dec_opcode   <= '0;
      dec_use_y    <= 1'b0;
      dec_indirect <= 1'b0;
      dec_opnd_cnt <= '0;
      illegal_rst  <= 1'b0;
    end else begin
      dec_vld     <= 1'b0;
      illegal_rst <= 1'b0;
      if (byte_vld) begin
        case (st_q)
          ST_OPND: begin
            left_q <= left_q - 1'b1;
            if (left_q == CW'(1)) st_q <= ST_FIRST;
          end
          default: begin
            if ((st_q == ST_FIRST) && (pre_kind != PK_NONE)) begin
              pend_q <= pre_kind;
              st_q   <= ST_OPC;
            end else if (is_legal) begin
              dec_vld      <= 1'b1;
              dec_opcode   <= byte_in;
              dec_use_y    <= mod_now.use_y;
              dec_indirect <= mod_now.indirect;
              dec_opnd_cnt <= opnd_cnt;
              left_q       <= opnd_cnt;
              pend_q       <= PK_NONE;
              st_q         <= (opnd_cnt == '0) ? ST_FIRST : ST_OPND;
            end else begin
              illegal_rst <= 1'b1;
              pend_q      <= PK_NONE;
              st_q        <= ST_FIRST;
            end
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/pbd_decode.sv
module pbd_decode
  import pbd_pkg::*;
#(
  parameter int                       W         = OP_W,
  parameter int                       CW        = CNT_W,
  parameter logic [W-1:0]             PRE_Y     = 8'h90,
  parameter logic [W-1:0]             PRE_IND   = 8'h92,
  parameter logic [W-1:0]             PRE_IND_Y = 8'h91,
  parameter logic [(1<<W)-1:0]        LEGAL_MAP = dflt_legal(),
  parameter logic [CW*(1<<W)-1:0]     LEN_MAP   = dflt_len()
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          byte_vld,
  input  logic [W-1:0]  byte_in,
  output logic          dec_vld,
  output logic [W-1:0]  dec_opcode,
  output logic          dec_use_y,
  output logic          dec_indirect,
  output logic [CW-1:0] dec_opnd_cnt,
  output logic          illegal_rst
);

  pre_kind_t     pre_kind;
  logic          is_legal;
  logic [CW-1:0] opnd_cnt;

  pbd_lookup #(
    .W(W), .CW(CW),
    .PRE_Y(PRE_Y), .PRE_IND(PRE_IND), .PRE_IND_Y(PRE_IND_Y),
    .LEGAL_MAP(LEGAL_MAP), .LEN_MAP(LEN_MAP)
  ) u_lookup (
    .byte_in  (byte_in),
    .pre_kind (pre_kind),
    .is_legal (is_legal),
    .opnd_cnt (opnd_cnt)
  );

  pbd_seq #(.W(W), .CW(CW)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .byte_vld     (byte_vld),
    .byte_in      (byte_in),
    .pre_kind     (pre_kind),
    .is_legal     (is_legal),
    .opnd_cnt     (opnd_cnt),
    .dec_vld      (dec_vld),
    .dec_opcode   (dec_opcode),
    .dec_use_y    (dec_use_y),
    .dec_indirect (dec_indirect),
    .dec_opnd_cnt (dec_opnd_cnt),
    .illegal_rst  (illegal_rst)
  );

endmodule

// File: rtl/pbd_decode_chk.sv
module pbd_decode_chk #(
  parameter int W  = 8,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          byte_vld,
  input logic [W-1:0]  byte_in,
  input logic          dec_vld,
  input logic [W-1:0]  dec_opcode,
  input logic          dec_use_y,
  input logic          dec_indirect,
  input logic [CW-1:0] dec_opnd_cnt,
  input logic          illegal_rst
);

  // R7
  ill_dec_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(illegal_rst && dec_vld));

  // R9
  opc_echo_chk: assert property (@(posedge clk) disable iff (rst)
    dec_vld |-> (dec_opcode == $past(byte_in)));

  // R11
  vld_src_chk: assert property (@(posedge clk) disable iff (rst)
    dec_vld |-> $past(byte_vld));

  // R11
  ill_src_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_rst |-> $past(byte_vld));

  // R9
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    dec_vld |-> (dec_opnd_cnt <= CW'(2)));

  // R10
  opnd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_vld && (dec_opnd_cnt != '0) && byte_vld) |=> (!dec_vld && !illegal_rst));

endmodule

bind pbd_decode pbd_decode_chk #(.W(W), .CW(CW)) u_chk (.*);

// File: tb/pbd_decode_tb.sv
`timescale 1ns/1ps
module pbd_decode_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       byte_vld = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic       dec_vld, dec_use_y, dec_indirect, illegal_rst;
  logic [7:0] dec_opcode;
  logic [1:0] dec_opnd_cnt;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pbd_decode u_dut (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_in(byte_in),
    .dec_vld(dec_vld), .dec_opcode(dec_opcode), .dec_use_y(dec_use_y),
    .dec_indirect(dec_indirect), .dec_opnd_cnt(dec_opnd_cnt),
    .illegal_rst(illegal_rst)
  );

  // Expected tables from R7 and R9.
  function automatic logic exp_legal(logic [7:0] b);
    return !(((b[7:4] == 4'h8) && (b[3:2] == 2'b11)) || b == 8'h31 || b == 8'h93);
  endfunction

  function automatic logic [1:0] exp_len(logic [7:0] b);
    if (!b[7]) return (b[5:4] == 2'd0) ? 2'd0 : ((b[5:4] == 2'd1) ? 2'd1 : 2'd2);
    return b[6] ? 2'd1 : 2'd0;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drive one byte at the current negedge, sample at the next negedge.
  task automatic put(logic [7:0] b);
    byte_vld = 1'b1;
    byte_in  = b;
    @(negedge clk);
    byte_vld = 1'b0;
  endtask

  task automatic expect_quiet(string req);
    chk(req, "dec_vld", int'(dec_vld), 0);
    chk(req, "illegal_rst", int'(illegal_rst), 0);
  endtask

  task automatic expect_dec(string req, logic [7:0] op, logic y, logic ind);
    chk(req, "dec_vld", int'(dec_vld), 1);
    chk(req, "illegal_rst", int'(illegal_rst), 0);
    chk(req, "dec_opcode", int'(dec_opcode), int'(op));
    chk(req, "dec_use_y", int'(dec_use_y), int'(y));
    chk(req, "dec_indirect", int'(dec_indirect), int'(ind));
    chk(req, "dec_opnd_cnt", int'(dec_opnd_cnt), int'(exp_len(op)));
  endtask

  task automatic expect_ill(string req);
    chk(req, "illegal_rst", int'(illegal_rst), 1);
    chk(req, "dec_vld", int'(dec_vld), 0);
  endtask

  task automatic t_reset_r1();
    expect_quiet("R1");
    put(8'h00);
    expect_dec("R1", 8'h00, 1'b0, 1'b0);
  endtask

  task automatic t_plain_r5();
    put(8'h10);
    expect_dec("R5", 8'h10, 1'b0, 1'b0);
    put(8'h8C);
    expect_quiet("R10");
    put(8'hA4);
    expect_dec("R5", 8'hA4, 1'b0, 1'b0);
  endtask

  task automatic t_pre_y_r2();
    put(8'h90);
    expect_quiet("R2");
    put(8'h40);
    expect_dec("R2", 8'h40, 1'b1, 1'b0);
  endtask

  task automatic t_pre_ind_r3();
    put(8'h92);
    expect_quiet("R3");
    put(8'h20);
    expect_dec("R3", 8'h20, 1'b0, 1'b1);
    put(8'h90);
    expect_quiet("R10");
    put(8'h31);
    expect_quiet("R10");
    put(8'h05);
    expect_dec("R10", 8'h05, 1'b0, 1'b0);
  endtask

  task automatic t_pre_indy_r4();
    put(8'h91);
    put(8'hC5);
    expect_dec("R4", 8'hC5, 1'b1, 1'b1);
    put(8'h93);
    expect_quiet("R10");
  endtask

  task automatic t_double_pre_r6();
    chk("R6", "table 0x92 legal", int'(exp_legal(8'h92)), 1);
    put(8'h90);
    expect_quiet("R6");
    put(8'h92);
    expect_dec("R6", 8'h92, 1'b1, 1'b0);
  endtask

  task automatic t_undef_r7();
    put(8'h8D);
    expect_ill("R7");
    @(negedge clk);
    expect_quiet("R7");
    put(8'h93);
    expect_ill("R7");
    @(negedge clk);
  endtask

  task automatic t_pre_pair_r8();
    put(8'h92);
    put(8'h8C);
    expect_ill("R8");
    @(negedge clk);
    put(8'h91);
    put(8'hE0);
    expect_dec("R8", 8'hE0, 1'b1, 1'b1);
    put(8'h00);
    expect_quiet("R8");
  endtask

  task automatic t_idle_r11();
    byte_vld = 1'b0;
    byte_in  = 8'h8C;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      expect_quiet("R11");
    end
    put(8'h90);
    byte_in = 8'h31;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      expect_quiet("R11");
    end
    put(8'h04);
    expect_dec("R11", 8'h04, 1'b1, 1'b0);
  endtask

  task automatic t_overlap_r12();
    put(8'h31);
    expect_ill("R12");
    put(8'h30);
    expect_dec("R12", 8'h30, 1'b0, 1'b0);
    put(8'h11);
    expect_quiet("R12");
    put(8'h12);
    expect_quiet("R12");
    put(8'h01);
    expect_dec("R12", 8'h01, 1'b0, 1'b0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_r1();
    t_plain_r5();
    t_pre_y_r2();
    t_pre_ind_r3();
    t_pre_indy_r4();
    t_double_pre_r6();
    t_undef_r7();
    t_pre_pair_r8();
    t_idle_r11();
    t_overlap_r12();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule